// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Operand Selection

This block is the integer execute stage of a 32-bit RISC core. It receives a 6-bit opcode, the values of two source registers and the 16-bit immediate field of the instruction. From these it builds the second operand and computes a 32-bit result. It also reports any opcode it cannot execute. The block has no registers: the result follows the inputs in the same cycle. The surrounding pipeline handles register reads, writeback and stalls.

Arithmetic, logic and shift operations each use a pair of opcodes. The even code of the pair takes the second register as its second operand. The odd code takes the extended immediate instead. The operation decides how the immediate is extended: add and subtract sign-extend it, and logic and shift operations zero-extend it. One more opcode places the immediate in the upper half of the result. Multiply, divide and remainder codes are recognised but not executed. They, and every code that this unit does not own, raise the unsupported flag and force the result to zero.

Top module: `int_alu`

## Requirements
- R1: Opcode 0x00 returns op_a + rs2_val and opcode 0x01 returns op_a + sign-extended imm16. The sum wraps modulo 2^32, and no overflow indication exists.
- R2: Opcode 0x02 returns op_a - rs2_val and opcode 0x03 returns op_a - sign-extended imm16, both wrapping modulo 2^32.
- R3: Opcodes 0x10/0x11 (AND), 0x12/0x13 (OR) and 0x14/0x15 (XOR) combine op_a with rs2_val (even code) or with the zero-extended imm16 (odd code).
- R4: Opcodes 0x16/0x17 return the bitwise complement of op_a XOR the second operand. The odd code uses the zero-extended imm16.
- R5: Opcodes 0x18/0x19 shift op_a left, filling with zeros. The shift amount is bits [4:0] of the second operand (rs2_val or zero-extended imm16), and all higher bits are ignored.
- R6: Opcodes 0x1A/0x1B shift op_a right, filling with zeros, using the same shift-amount rule as R5.
- R7: Opcodes 0x1C/0x1D shift op_a right and copy bit 31 of op_a into the vacated bits, using the same shift-amount rule as R5.
- R8: Opcode 0x1F returns {imm16, 16'h0000}. op_a and rs2_val are ignored.
- R9: Opcodes 0x04 to 0x0F drive unsupported to 1 and result to 0.
- R10: Opcode 0x1E and opcodes 0x20 to 0x3F drive unsupported to 1 and result to 0. Every opcode listed in R1 to R8 drives unsupported to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Operation code; bit 0 selects the immediate form for paired operations |
| op_a | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value, used by even opcodes |
| imm16 | input | 16 | Immediate field of the instruction |
| result | output | 32 | Computed result, zero when unsupported |
| unsupported | output | 1 | High when the opcode is not executed by this unit |

## Verification
Both outputs are purely combinational, so each result is due in the same cycle as its stimulus, with zero register stages in between. The bench changes the inputs one time unit after a rising clock edge and samples half a period later, on the falling edge. Each vector is therefore compared after the logic has settled and before the next stimulus is applied. The expected values come from a reference model in the bench. The bench sweeps all 64 opcodes over a grid of operand and immediate patterns. It then sweeps every shift amount from 0 to 31, with junk in the upper bits of the second operand.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int OPC_W = 6;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUB,
        FN_BITWISE,
        FN_SHIFT,
        FN_UPPER,
        FN_NONE
    } fn_e;

    typedef enum logic [1:0] {
        BW_AND,
        BW_OR,
        BW_XOR,
        BW_XNOR
    } bw_e;

    typedef enum logic [1:0] {
        SH_LEFT,
        SH_RLOG,
        SH_RARITH,
        SH_IDLE
    } sh_e;

    typedef struct packed {
        fn_e  fn;
        bw_e  bw;
        sh_e  sh;
        logic use_imm;
        logic sext;
        logic unsup;
    } dec_t;

    function automatic dec_t decode(input logic [OPC_W-1:0] opc);
        dec_t d;
        d.fn      = FN_NONE;
        d.bw      = BW_AND;
        d.sh      = SH_IDLE;
        d.use_imm = opc[0];
        d.sext    = 1'b0;
        d.unsup   = 1'b0;
        case (opc[5:1])
            5'b00000: begin d.fn = FN_ADD; d.sext = 1'b1; end
            5'b00001: begin d.fn = FN_SUB; d.sext = 1'b1; end
            5'b01000: begin d.fn = FN_BITWISE; d.bw = BW_AND;  end
            5'b01001: begin d.fn = FN_BITWISE; d.bw = BW_OR;   end
            5'b01010: begin d.fn = FN_BITWISE; d.bw = BW_XOR;  end
            5'b01011: begin d.fn = FN_BITWISE; d.bw = BW_XNOR; end
            5'b01100: begin d.fn = FN_SHIFT; d.sh = SH_LEFT;   end
            5'b01101: begin d.fn = FN_SHIFT; d.sh = SH_RLOG;   end
            5'b01110: begin d.fn = FN_SHIFT; d.sh = SH_RARITH; end
            5'b01111: begin
                if (opc[0]) d.fn = FN_UPPER;
                else        d.unsup = 1'b1;
            end
            default: d.unsup = 1'b1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/int_alu_opsel.sv
module int_alu_opsel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] rs2_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              sext,
    output logic [DATA_W-1:0] op_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [EXT_W-1:0] ext_bits;

    assign ext_bits = sext ? {EXT_W{imm[IMM_W-1]}} : {EXT_W{1'b0}};
    assign op_b     = use_imm ? {ext_bits, imm} : rs2_val;

    always_comb begin
        if (use_imm && !sext)
            AST_ZEXT_UPPER: assert (op_b[DATA_W-1:IMM_W] == '0) else $error("zero extension leaked"); // R3
        if (use_imm)
            AST_IMM_LOW: assert (op_b[IMM_W-1:0] == imm) else $error("immediate low half lost"); // R1
    end
endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum
);
    logic [DATA_W-1:0] b_eff;

    assign b_eff = do_sub ? ~b : b;
    assign sum   = a + b_eff + {{(DATA_W-1){1'b0}}, do_sub};

    always_comb begin
        if (do_sub)
            AST_SUB_INVERSE: assert (DATA_W'(sum + b) == a) else $error("difference inconsistent"); // R2
        else
            AST_ADD_INVERSE: assert (DATA_W'(sum - b) == a) else $error("sum inconsistent"); // R1
    end
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  bw_e               sel,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        case (sel)
            BW_AND:  y = a & b;
            BW_OR:   y = a | b;
            BW_XOR:  y = a ^ b;
            default: y = ~(a ^ b);
        endcase
    end

    always_comb begin
        if (sel == BW_XNOR)
            AST_XNOR_COMPL: assert ((y ^ a ^ b) == '1) else $error("xnor not complement"); // R4
        if (sel == BW_AND)
            AST_AND_SUBSET: assert ((y & ~a) == '0) else $error("and set foreign bit"); // R3
    end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         a,
    input  logic [$clog2(DATA_W)-1:0] amt,
    input  sh_e                       kind,
    output logic [DATA_W-1:0]         y
);
    localparam int SHAMT_W = $clog2(DATA_W);

    logic              go_left;
    logic              fill;
    logic [DATA_W-1:0] a_rev;
    logic [DATA_W-1:0] out_rev;
    logic [DATA_W-1:0] stg [SHAMT_W+1];

    assign go_left = (kind == SH_LEFT);
    assign fill    = (kind == SH_RARITH) & a[DATA_W-1];

    always_comb begin
        for (int k = 0; k < DATA_W; k++) a_rev[k] = a[DATA_W-1-k];
    end

    assign stg[0] = go_left ? a_rev : a;

    for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
        localparam int DIST = 1 << i;
        assign stg[i+1] = amt[i] ? {{DIST{fill}}, stg[i][DATA_W-1:DIST]} : stg[i];
    end

    always_comb begin
        for (int k = 0; k < DATA_W; k++) out_rev[k] = stg[SHAMT_W][DATA_W-1-k];
    end

    assign y = go_left ? out_rev : stg[SHAMT_W];

    always_comb begin
        if (amt == '0)
            AST_SHIFT_ZERO_IDENT: assert (y == a) else $error("zero shift altered value"); // R5
        if (kind == SH_RARITH)
            AST_SAR_SIGN: assert (y[DATA_W-1] == a[DATA_W-1]) else $error("sign not kept"); // R7
        if (kind == SH_RLOG && amt != '0)
            AST_SLR_TOP_ZERO: assert (y[DATA_W-1] == 1'b0) else $error("logical right shift filled ones"); // R6
        if (kind == SH_LEFT && amt != '0)
            AST_SLL_BOTTOM_ZERO: assert (y[0] == 1'b0) else $error("left shift filled ones"); // R5
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] rs2_val,
    input  logic [IMM_W-1:0]  imm16,
    output logic [DATA_W-1:0] result,
    output logic              unsupported
);
    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int LOW_W   = DATA_W - IMM_W;

    dec_t              dec;
    logic [DATA_W-1:0] op_b;
    logic [DATA_W-1:0] as_out;
    logic [DATA_W-1:0] bw_out;
    logic [DATA_W-1:0] sh_out;

    assign dec = decode(opcode);

    int_alu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .rs2_val (rs2_val),
        .imm     (imm16),
        .use_imm (dec.use_imm),
        .sext    (dec.sext),
        .op_b    (op_b)
    );

    int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a      (op_a),
        .b      (op_b),
        .do_sub (dec.fn == FN_SUB),
        .sum    (as_out)
    );

    int_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .sel (dec.bw),
        .y   (bw_out)
    );

    int_alu_shift #(.DATA_W(DATA_W)) u_shift (
        .a    (op_a),
        .amt  (op_b[SHAMT_W-1:0]),
        .kind (dec.sh),
        .y    (sh_out)
    );

    always_comb begin
        case (dec.fn)
            FN_ADD, FN_SUB: result = as_out;
            FN_BITWISE:     result = bw_out;
            FN_SHIFT:       result = sh_out;
            FN_UPPER:       result = {imm16, {LOW_W{1'b0}}};
            default:        result = '0;
        endcase
    end

    assign unsupported = dec.unsup;

    always_comb begin
        if (unsupported)
            AST_UNSUP_ZERO: assert (result == '0) else $error("unsupported op left a result"); // R9
        if (opcode >= 6'h04 && opcode <= 6'h0F)
            AST_MULDIV_FLAG: assert (unsupported) else $error("mul/div code not flagged"); // R9
        if (opcode[5] || opcode == 6'h1E)
            AST_FOREIGN_FLAG: assert (unsupported) else $error("foreign code not flagged"); // R10
        if (opcode == 6'h1F)
            AST_UPPER_LOW_ZERO: assert (result[LOW_W-1:0] == '0 && !unsupported) else $error("upper load low half"); // R8
    end
endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = '0;
    logic [31:0] op_a = '0;
    logic [31:0] rs2_val = '0;
    logic [15:0] imm16 = '0;
    logic [31:0] result;
    logic        unsupported;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_alu dut_i (
        .opcode      (opcode),
        .op_a        (op_a),
        .rs2_val     (rs2_val),
        .imm16       (imm16),
        .result      (result),
        .unsupported (unsupported)
    );

    logic [31:0] pats [10] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
                               32'h7FFF_FFFF, 32'h1234_5678, 32'hA5A5_A5A5, 32'h5A5A_5A5A,
                               32'h0000_FFFF, 32'hFFFF_0000};
    logic [15:0] imms [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

    function automatic string req_of(input logic [5:0] op);
        case (op[5:1])
            5'h00: return "R1";
            5'h01: return "R2";
            5'h08, 5'h09, 5'h0A: return "R3";
            5'h0B: return "R4";
            5'h0C: return "R5";
            5'h0D: return "R6";
            5'h0E: return "R7";
            5'h0F: return op[0] ? "R8" : "R10";
            default: return (op >= 6'h04 && op <= 6'h0F) ? "R9" : "R10";
        endcase
    endfunction

    task automatic model(input logic [5:0] op, input logic [31:0] a, input logic [31:0] r2,
                         input logic [15:0] im, output logic [31:0] exp_r, output logic exp_u);
        logic [31:0] sx, zx, b_s, b_z;
        int unsigned sa;
        sx  = {{16{im[15]}}, im};
        zx  = {16'h0000, im};
        b_s = op[0] ? sx : r2;
        b_z = op[0] ? zx : r2;
        sa  = b_z % 32;
        exp_u = 1'b0;
        case (op)
            6'h00, 6'h01: exp_r = a + b_s;
            6'h02, 6'h03: exp_r = a - b_s;
            6'h10, 6'h11: exp_r = a & b_z;
            6'h12, 6'h13: exp_r = a | b_z;
            6'h14, 6'h15: exp_r = a ^ b_z;
            6'h16, 6'h17: exp_r = ~(a ^ b_z);
            6'h18, 6'h19: exp_r = a << sa;
            6'h1A, 6'h1B: exp_r = a >> sa;
            6'h1C, 6'h1D: exp_r = 32'($signed(a) >>> sa);
            6'h1F:        exp_r = im * 32'h0001_0000;
            default: begin exp_r = 32'h0; exp_u = 1'b1; end
        endcase
    endtask

    task automatic apply(input logic [5:0] op, input logic [31:0] a, input logic [31:0] r2,
                         input logic [15:0] im);
        logic [31:0] er;
        logic        eu;
        @(posedge clk);
        #1;
        opcode = op; op_a = a; rs2_val = r2; imm16 = im;
        model(op, a, r2, im, er, eu);
        @(negedge clk);
        n_vec++;
        if (result !== er || unsupported !== eu) begin
            n_fail++;
            $display("FAIL %s op=%02h a=%08h r2=%08h imm=%04h actual=%08h/%0b expected=%08h/%0b",
                     req_of(op), op, a, r2, im, result, unsupported, er, eu);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1: idle inputs (add of zeros) give a zero result and no flag
        apply(6'h00, 32'h0, 32'h0, 16'h0);
        // R1 R2: wrap corner cases
        apply(6'h00, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0);
        apply(6'h01, 32'h0000_0000, 32'h0, 16'h8000);
        apply(6'h03, 32'h0000_0000, 32'h0, 16'h0001);
        apply(6'h02, 32'h8000_0000, 32'h0000_0001, 16'h0);
        // R8: upper load ignores both registers
        apply(6'h1F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF);
        // Sweep of all opcodes over operand grids (R1..R10)
        for (int op = 0; op < 64; op++)
            for (int ia = 0; ia < 10; ia++)
                for (int ib = 0; ib < 4; ib++)
                    for (int ii = 0; ii < 6; ii++)
                        apply(6'(op), pats[ia], pats[(ib*3+1) % 10], imms[ii]);
        // R5 R6 R7: every shift amount, junk in the upper bits of the amount
        for (int op = 6'h18; op <= 6'h1D; op++)
            for (int s = 0; s < 32; s++) begin
                apply(6'(op), 32'h8765_4321, 32'(s) | 32'hFFFF_FFE0, 16'(s) | 16'hFFE0);
                apply(6'(op), 32'h4321_8765, 32'(s), 16'(s));
            end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule